// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block runs one shared analog-to-digital converter through two registers on a simple synchronous register port. Software programs an enable bit, a sync bit and a one-hot channel mask in the control register, then writes the same value again with the start bit set. The sequencer waits for the reference to warm up, holds the input-select phase, then runs the conversion phase. Every wait is counted in clock cycles. At the end it latches a result into the data register and sets a valid flag. Software polls that flag. A one-cycle completion pulse is also provided for interrupt wiring.

In sync mode the sequence stops after the warm-up and waits for an external trigger pin before the select phase begins. The analog converter itself is not part of this block. A behavioural result source stands in for it and produces a predictable code from the channel mask and the number of completed conversions.

Top module: `adcseq_top`

## Requirements
- R1: After reset, both registers read as zero, and `busy` and `adc_irq` are low.
- R2: Address 0 is the control register: bit 0 enable, bit 1 sync, bit 2 start (reads back as `busy`), bits 6:3 channel mask. Address 1 is the data register, and writes to it have no effect. `bus_rdata` is registered and shows the register selected by `bus_addr` at the previous clock edge.
- R3: The reference timer starts when enable goes high. A start that is written together with enable enters the select phase REF_CYC+1 edges after the write, so the valid flag sets REF_CYC+1+SEL_CYC+CONV_CYC edges after the write.
- R4: With the reference ready and sync off, the valid flag sets SEL_CYC+CONV_CYC edges after the start write.
- R5: With sync on, the sequence waits for `sync_trig` to go high. The pin passes through a two-stage synchronizer, and the select phase begins on the third edge after the pin rises.
- R6: The data register holds the valid flag in bit 15 and a 10-bit result in bits 9:0. The result is {completed-conversion count mod 64, channel mask}, and bits 14:10 read zero.
- R7: Any write to the control register clears the valid flag. A write with start clear aborts any sequence in progress, including a sync wait, so that no result lands.
- R8: Writing enable clear returns the sequencer to idle and restarts the reference timer. A start written with enable clear is ignored.
- R9: `adc_irq` is high for exactly one cycle. That cycle is the one in which the valid flag first reads set internally, on the edge where the conversion completes.
- R10: A start written while a sequence is running restarts the timing from that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all phase timing is counted on it |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 control, 1 data |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| sync_trig | input | 1 | External conversion trigger (asynchronous) |
| busy | output | 1 | Sequence in progress |
| adc_irq | output | 1 | One-cycle completion pulse |

## Verification
Conversions are run in several ways:
- started in the same write that enables the converter, and again with the reference already warm, so that the warm-up delay can be told apart from the select and convert phases;
- gated by the trigger, with the trigger held low for a long time first;
- aborted in the middle of the conversion phase and during the trigger wait;
- restarted partway through;
- requested while disabled.

Each latency is measured as an edge count against the sum given by the requirements. Each result code is compared against the mask and the completion count, which shows whether aborted or restarted runs were wrongly counted. A behavioural model also compares the read data, `busy` and the pulse on every clock.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WREF  = 3'd1,
    ST_WTRIG = 3'd2,
    ST_SEL   = 3'd3,
    ST_CONV  = 3'd4
  } seq_state_e;

  localparam int CTL_EN       = 0;
  localparam int CTL_SYNC     = 1;
  localparam int CTL_GO       = 2;
  localparam int CTL_MASK_LSB = 3;

  localparam logic ADDR_CTL = 1'b0;
  localparam logic ADDR_DAT = 1'b1;
endpackage

// File: rtl/adcseq_warmup.sv
module adcseq_warmup #(
  parameter int REF_CYC = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic en_q,
  output logic ready
);
  localparam int RW = $clog2(REF_CYC + 1);
  localparam logic [RW-1:0] REF_FULL = RW'(REF_CYC);

  logic [RW-1:0] warm_cnt;

  always_ff @(posedge clk) begin
    if (rst || !en_q) warm_cnt <= '0;
    else if (warm_cnt != REF_FULL) warm_cnt <= warm_cnt + 1'b1;
  end

  assign ready = (warm_cnt == REF_FULL);

  // R3: once warm, the reference stays ready while enable stays high
  p_warm_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (en_q && $past(en_q) && $past(ready)) |-> ready);
endmodule

// File: rtl/adcseq_result_src.sv
module adcseq_result_src #(
  parameter int RES_W = 10,
  parameter int CH_N  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [CH_N-1:0]  mask,
  output logic [RES_W-1:0] sample
);
  localparam int CNT_W = RES_W - CH_N;

  logic [CNT_W-1:0] conv_cnt;

  always_ff @(posedge clk) begin
    if (rst) conv_cnt <= '0;
    else if (capture) conv_cnt <= conv_cnt + 1'b1;
  end

  assign sample = {conv_cnt, mask};

  // R6: every completed conversion advances the stand-in count by one
  p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
    capture |=> (conv_cnt == $past(conv_cnt) + 1'b1));
endmodule

// File: rtl/adcseq_fsm.sv
module adcseq_fsm
  import adcseq_pkg::*;
#(
  parameter int REF_CYC  = 60,
  parameter int SEL_CYC  = 51,
  parameter int CONV_CYC = 102
) (
  input  logic clk,
  input  logic rst,
  input  logic en_q,
  input  logic sync_q,
  input  logic ctl_wr,
  input  logic wr_en_bit,
  input  logic wr_go,
  input  logic wr_sync,
  input  logic trig_pin,
  output logic busy,
  output logic done
);
  localparam int PH_MAX = (SEL_CYC > CONV_CYC) ? SEL_CYC : CONV_CYC;
  localparam int PW = $clog2(PH_MAX + 1);
  localparam logic [PW-1:0] SEL_LAST  = PW'(SEL_CYC - 1);
  localparam logic [PW-1:0] CONV_LAST = PW'(CONV_CYC - 1);

  seq_state_e    state, state_n;
  logic [PW-1:0] ph_cnt, ph_cnt_n;
  logic          ref_ready;
  logic          trig_m, trig_s;

  adcseq_warmup #(.REF_CYC(REF_CYC)) u_warm (
    .clk   (clk),
    .rst   (rst),
    .en_q  (en_q),
    .ready (ref_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_m <= 1'b0;
      trig_s <= 1'b0;
    end else begin
      trig_m <= trig_pin;
      trig_s <= trig_m;
    end
  end

  always_comb begin
    state_n  = state;
    ph_cnt_n = ph_cnt;
    done     = 1'b0;
    if (ctl_wr) begin
      ph_cnt_n = '0;
      if (wr_en_bit && wr_go)
        state_n = !ref_ready ? ST_WREF : (wr_sync ? ST_WTRIG : ST_SEL);
      else
        state_n = ST_IDLE;
    end else if (!en_q) begin
      state_n = ST_IDLE;
    end else begin
      case (state)
        ST_WREF: if (ref_ready) begin
          state_n  = sync_q ? ST_WTRIG : ST_SEL;
          ph_cnt_n = '0;
        end
        ST_WTRIG: if (trig_s) begin
          state_n  = ST_SEL;
          ph_cnt_n = '0;
        end
        ST_SEL: begin
          if (ph_cnt == SEL_LAST) begin
            state_n  = ST_CONV;
            ph_cnt_n = '0;
          end else ph_cnt_n = ph_cnt + 1'b1;
        end
        ST_CONV: begin
          if (ph_cnt == CONV_LAST) begin
            state_n  = ST_IDLE;
            ph_cnt_n = '0;
            done     = 1'b1;
          end else ph_cnt_n = ph_cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      ph_cnt <= '0;
    end else begin
      state  <= state_n;
      ph_cnt <= ph_cnt_n;
    end
  end

  assign busy = (state != ST_IDLE);

  // R8: with enable low the sequencer sits idle
  p_idle_when_off_r8: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> (state == ST_IDLE));
  // R3: input selection never runs on a cold reference
  p_sel_needs_ref_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEL) |-> ref_ready);
  // R5: without a synchronized trigger the wait persists
  p_trig_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WTRIG && !trig_s && !ctl_wr && en_q) |=> (state == ST_WTRIG));
  // R4: conversion is entered only from input selection
  p_conv_from_sel_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CONV && $past(state) != ST_CONV) |-> ($past(state) == ST_SEL));
  // R7: a control write without start leaves the sequencer idle
  p_abort_r7: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !wr_go) |=> (state == ST_IDLE));
endmodule

// File: rtl/adcseq_regs.sv
module adcseq_regs
  import adcseq_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CH_N  = 4,
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             busy,
  input  logic             done,
  input  logic [RES_W-1:0] sample,
  output logic             en_q,
  output logic             sync_q,
  output logic [CH_N-1:0]  mask_q,
  output logic             ctl_wr,
  output logic             wr_en_bit,
  output logic             wr_go,
  output logic             wr_sync,
  output logic [DW-1:0]    bus_rdata,
  output logic             irq
);
  localparam int FIELD_TOP = CTL_MASK_LSB + CH_N;

  logic             valid_q;
  logic [RES_W-1:0] result_q;
  logic [DW-1:0]    ctl_view, dat_view;
  logic             unused_wbits;

  assign ctl_wr       = bus_wr && (bus_addr == ADDR_CTL);
  assign wr_en_bit    = bus_wdata[CTL_EN];
  assign wr_go        = bus_wdata[CTL_GO];
  assign wr_sync      = bus_wdata[CTL_SYNC];
  assign unused_wbits = ^bus_wdata[DW-1:FIELD_TOP];

  always_comb begin
    ctl_view                       = '0;
    ctl_view[CTL_EN]               = en_q;
    ctl_view[CTL_SYNC]             = sync_q;
    ctl_view[CTL_GO]               = busy;
    ctl_view[CTL_MASK_LSB +: CH_N] = mask_q;
    dat_view                       = '0;
    dat_view[DW-1]                 = valid_q;
    dat_view[RES_W-1:0]            = result_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      sync_q    <= 1'b0;
      mask_q    <= '0;
      valid_q   <= 1'b0;
      result_q  <= '0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (ctl_wr) begin
        en_q    <= wr_en_bit;
        sync_q  <= wr_sync;
        mask_q  <= bus_wdata[CTL_MASK_LSB +: CH_N];
        valid_q <= 1'b0;
      end else if (done) begin
        valid_q  <= 1'b1;
        result_q <= sample;
      end
      irq       <= done;
      bus_rdata <= (bus_addr == ADDR_DAT) ? dat_view : ctl_view;
    end
  end

  // R7: a control write always drops the valid flag
  p_wr_clears_valid_r7: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> !valid_q);
  // R4: valid only appears at the end of a running sequence
  p_valid_after_busy_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> $past(busy));
  // R9: the completion pulse lasts one cycle
  p_irq_single_r9: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  // R9: the pulse coincides with a set valid flag
  p_irq_with_valid_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> valid_q);
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top #(
  parameter int DW       = 16,
  parameter int CH_N     = 4,
  parameter int RES_W    = 10,
  parameter int REF_CYC  = 60,
  parameter int SEL_CYC  = 51,
  parameter int CONV_CYC = 102
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          sync_trig,
  output logic          busy,
  output logic          adc_irq
);
  logic             en_q, sync_q, ctl_wr, wr_en_bit, wr_go, wr_sync, done;
  logic [CH_N-1:0]  mask_q;
  logic [RES_W-1:0] sample;

  adcseq_regs #(.DW(DW), .CH_N(CH_N), .RES_W(RES_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .busy      (busy),
    .done      (done),
    .sample    (sample),
    .en_q      (en_q),
    .sync_q    (sync_q),
    .mask_q    (mask_q),
    .ctl_wr    (ctl_wr),
    .wr_en_bit (wr_en_bit),
    .wr_go     (wr_go),
    .wr_sync   (wr_sync),
    .bus_rdata (bus_rdata),
    .irq       (adc_irq)
  );

  adcseq_fsm #(.REF_CYC(REF_CYC), .SEL_CYC(SEL_CYC), .CONV_CYC(CONV_CYC)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .en_q      (en_q),
    .sync_q    (sync_q),
    .ctl_wr    (ctl_wr),
    .wr_en_bit (wr_en_bit),
    .wr_go     (wr_go),
    .wr_sync   (wr_sync),
    .trig_pin  (sync_trig),
    .busy      (busy),
    .done      (done)
  );

  adcseq_result_src #(.RES_W(RES_W), .CH_N(CH_N)) u_src (
    .clk     (clk),
    .rst     (rst),
    .capture (done),
    .mask    (mask_q),
    .sample  (sample)
  );
endmodule

// File: tb/tb_adcseq_top.sv
module tb_adcseq_top;
  localparam int REF  = 60;
  localparam int SEL  = 51;
  localparam int CONV = 102;
  localparam logic [15:0] EN = 16'h0001, SY = 16'h0002, GO = 16'h0004;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_addr = 1'b1;
  logic [15:0] bus_wdata = '0;
  logic        sync_trig = 1'b0;
  logic [15:0] bus_rdata;
  logic        busy, adc_irq;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int exp_n = 0;
  string cur_req = "R1";

  adcseq_top dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sync_trig(sync_trig),
    .busy(busy), .adc_irq(adc_irq)
  );

  always #2.5 clk = ~clk;

  // behavioural reference model, advanced on every rising edge
  int m_en, m_sy, m_mask, m_ref, m_st, m_cnt, m_valid, m_res, m_conv, m_irq, m_t1, m_t2;
  int m_rdata;
  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_sy = 0; m_mask = 0; m_ref = 0; m_st = 0; m_cnt = 0;
      m_valid = 0; m_res = 0; m_conv = 0; m_irq = 0; m_t1 = 0; m_t2 = 0; m_rdata = 0;
    end else begin
      automatic bit wrc  = bus_wr && !bus_addr;
      automatic bit rdy  = (m_ref == REF);
      automatic bit fin  = !wrc && m_en != 0 && m_st == 4 && m_cnt == CONV - 1;
      automatic int nst  = m_st;
      automatic int ncnt = m_cnt;
      m_rdata = bus_addr ? ((m_valid << 15) | m_res)
                         : (m_en | (m_sy << 1) | ((m_st != 0) << 2) | (m_mask << 3));
      if (wrc) begin
        ncnt = 0;
        if (bus_wdata[0] && bus_wdata[2]) nst = !rdy ? 1 : (bus_wdata[1] ? 2 : 3);
        else nst = 0;
      end else if (m_en == 0) nst = 0;
      else if (m_st == 1) begin if (rdy) begin nst = m_sy ? 2 : 3; ncnt = 0; end end
      else if (m_st == 2) begin if (m_t2 != 0) begin nst = 3; ncnt = 0; end end
      else if (m_st == 3) begin
        if (m_cnt == SEL - 1) begin nst = 4; ncnt = 0; end else ncnt = m_cnt + 1;
      end else if (m_st == 4) begin
        if (fin) begin nst = 0; ncnt = 0; end else ncnt = m_cnt + 1;
      end
      if (m_en == 0) m_ref = 0; else if (m_ref < REF) m_ref = m_ref + 1;
      if (wrc) begin
        m_en = bus_wdata[0]; m_sy = bus_wdata[1]; m_mask = bus_wdata[6:3]; m_valid = 0;
      end else if (fin) begin
        m_valid = 1; m_res = ((m_conv % 64) << 4) | m_mask; m_conv = m_conv + 1;
      end
      m_irq = fin;
      m_st = nst; m_cnt = ncnt;
      m_t2 = m_t1; m_t1 = sync_trig;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      chk({cur_req, " rdata"}, int'(bus_rdata), m_rdata);
      chk({cur_req, " busy"}, int'(busy), int'(m_st != 0));
      chk({cur_req, " irq"}, int'(adc_irq), m_irq);
    end
    if (cyc > 100000) begin
      bad++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr_reg(input logic a, input logic [15:0] v);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk); bus_wr = 1'b0; bus_addr = 1'b1;
  endtask

  task automatic rd_reg(input logic a, output int v);
    @(negedge clk); bus_addr = a;
    @(negedge clk); v = int'(bus_rdata); bus_addr = 1'b1;
  endtask

  task automatic measure(input int maxc, output int kv, output int ki, output int nirq);
    kv = -1; ki = -1; nirq = 0;
    for (int c = 1; c <= maxc; c++) begin
      @(negedge clk);
      if (adc_irq) begin nirq++; if (ki < 0) ki = c; end
      if (bus_rdata[15]) begin kv = c; break; end
    end
  endtask

  function automatic int exp_res(input int n, input int m);
    return 32'h8000 | ((n % 64) << 4) | m;
  endfunction

  initial begin
    int v, kv, ki, ni;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    cur_req = "R1";
    rd_reg(1'b0, v); chk("R1 ctrl after reset", v, 0);
    rd_reg(1'b1, v); chk("R1 data after reset", v, 0);
    chk("R1 busy after reset", int'(busy), 0);

    // R3: start together with enable; warm-up precedes the phases
    cur_req = "R3";
    wr_reg(1'b0, EN | GO | (16'h5 << 3));
    measure(REF + SEL + CONV + 20, kv, ki, ni);
    chk("R3 latency incl warm-up", kv, REF + SEL + CONV + 2);
    chk("R9 irq edge", ki, REF + SEL + CONV + 1);
    chk("R9 irq pulse count", ni, 1);
    chk("R6 result code", int'(bus_rdata), exp_res(exp_n, 5)); exp_n++;

    // R4: warm reference, plain conversion
    cur_req = "R4";
    wr_reg(1'b0, EN | GO | (16'hA << 3));
    measure(SEL + CONV + 20, kv, ki, ni);
    chk("R4 latency", kv, SEL + CONV + 1);
    chk("R6 result code second", int'(bus_rdata), exp_res(exp_n, 10)); exp_n++;

    // R2: data register writes are ignored
    cur_req = "R2";
    wr_reg(1'b1, 16'h0000);
    rd_reg(1'b1, v); chk("R2 data write ignored", v, exp_res(exp_n - 1, 10));

    // R7: abort in conversion phase
    cur_req = "R7";
    wr_reg(1'b0, EN | GO | (16'h3 << 3));
    repeat (80) @(negedge clk);
    wr_reg(1'b0, EN | (16'h3 << 3));
    measure(SEL + CONV + 30, kv, ki, ni);
    chk("R7 no result after abort", kv, -1);
    chk("R7 no irq after abort", ni, 0);
    chk("R7 idle after abort", int'(busy), 0);

    // R5: sync gating
    cur_req = "R5";
    wr_reg(1'b0, EN | SY | GO | (16'h8 << 3));
    repeat (300) @(negedge clk);
    chk("R5 still waiting busy", int'(busy), 1);
    chk("R5 still waiting no valid", int'(bus_rdata[15]), 0);
    @(negedge clk); sync_trig = 1'b1;
    measure(SEL + CONV + 20, kv, ki, ni);
    chk("R5 latency from trigger", kv, 3 + SEL + CONV + 1);
    chk("R6 result code sync", int'(bus_rdata), exp_res(exp_n, 8)); exp_n++;
    sync_trig = 1'b0;

    // R7: abort during sync wait
    cur_req = "R7";
    wr_reg(1'b0, EN | SY | GO | (16'h1 << 3));
    repeat (20) @(negedge clk);
    wr_reg(1'b0, EN | SY | (16'h1 << 3));
    chk("R7 valid cleared by write", int'(bus_rdata[15]), 0);
    sync_trig = 1'b1;
    measure(SEL + CONV + 30, kv, ki, ni);
    chk("R7 sync wait aborted", kv, -1);
    sync_trig = 1'b0;

    // R8: disable, ignored start, cold restart
    cur_req = "R8";
    wr_reg(1'b0, 16'h0000);
    chk("R8 idle when disabled", int'(busy), 0);
    wr_reg(1'b0, GO | (16'h2 << 3));
    repeat (5) @(negedge clk);
    chk("R8 start ignored busy", int'(busy), 0);
    measure(SEL + CONV + 30, kv, ki, ni);
    chk("R8 start ignored no result", kv, -1);
    wr_reg(1'b0, EN | GO | (16'h2 << 3));
    measure(REF + SEL + CONV + 20, kv, ki, ni);
    chk("R8 warm-up restarted", kv, REF + SEL + CONV + 2);
    chk("R6 result code after re-enable", int'(bus_rdata), exp_res(exp_n, 2)); exp_n++;

    // R10: restart mid-sequence
    cur_req = "R10";
    wr_reg(1'b0, EN | GO | (16'h4 << 3));
    repeat (100) @(negedge clk);
    wr_reg(1'b0, EN | GO | (16'h6 << 3));
    measure(SEL + CONV + 20, kv, ki, ni);
    chk("R10 latency from restart", kv, SEL + CONV + 1);
    chk("R10 single completion count", int'(bus_rdata), exp_res(exp_n, 6)); exp_n++;

    // R2: control readback layout
    cur_req = "R2";
    wr_reg(1'b0, EN | SY | (16'hF << 3));
    rd_reg(1'b0, v); chk("R2 control readback", v, 32'h7B);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule